// File: doc/BRIEF.md
# Serial Converter Host Controller

This block is the processor-side master for a serial 8-bit analog-to-digital converter with an input multiplexer. A request names a positive channel, an optional negative channel and a single-ended or differential mode. The controller lowers chip select and runs a divided serial clock. It shifts out a start bit and the multiplexer word, then waits for the converter's busy status to rise. It collects the result, which arrives most significant bit first, and the copy that follows it least significant bit first. It reports the word together with a flag that marks any disagreement between the two copies.

The outgoing data pin has an enable, so the data-in and data-out wires of the converter can share one line. When the shared-line option is on, the controller lets go of the line once the address has been sent. A request for a differential pair whose channels are not neighbours is refused at once, and no transaction starts. A converter whose status line never completes its rise and fall ends the transaction with a timeout flag.

Top module: `sc_host`

## Requirements
- R1: While `cs_n` is high, `sclk` is low. `cs_n` goes low when a legal request is accepted and stays low until the result has been read.
- R2: The first bit shifted out is a 1 (the start bit). `sdo` changes only while `sclk` is low, so it is stable at every rising edge of `sclk`.
- R3: After the start bit come ADDR_W+1 multiplexer bits, where ADDR_W = log2(N_CH). In order they are: 1 for single-ended or 0 for differential, then bit 0 of `req_pos`, then `req_pos[ADDR_W-1:1]` most significant first. With 8 channels the word is {sgl, pos[0], pos[2], pos[1]}.
- R4: `sdi` is sampled at each rising edge of `sclk`. The bit taken in the cycle where `sars` is first seen high is a leading zero and is discarded. The next DATA_W bits form `res_data`, most significant first.
- R5: The following DATA_W-1 bits are bits 1 through DATA_W-1, least significant first. `res_mismatch` is 1 when they differ from the same bits of `res_data`.
- R6: Each transaction ends with `cs_n` going high. It stays high for at least two system clocks before the next transaction can start, and every transaction sends a fresh start bit.
- R7: A differential request is legal only when `req_pos` and `req_neg` form the pair {2k, 2k+1}, in either order. An illegal request pulses `req_reject` for one clock and leaves `cs_n` high.
- R8: Each phase of `sclk` lasts `div_half`+1 system clocks. The first rising edge comes `div_half`+1 clocks after `cs_n` falls.
- R9: With SHARED=1, `sdo_oe` falls at the falling edge of `sclk` that follows the last address bit. It is never high while the converter drives the line, and it is low whenever `cs_n` is high.
- R10: If `sars` has not been seen high within TO_CYC rising edges after the address, or has not returned low during the least-significant-first stream, `res_timeout` is set and the transaction ends.
- R11: `res_valid` is a single-clock pulse, issued with `cs_n` already high, that carries `res_data`, `res_mismatch` and `res_timeout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_half | input | DIV_W | System clocks per serial clock phase, minus one |
| req | input | 1 | Conversion request, taken while `busy` is low |
| req_pos | input | ADDR_W | Positive (or only) channel |
| req_neg | input | ADDR_W | Negative channel for differential requests |
| req_diff | input | 1 | 1 = differential, 0 = single-ended |
| busy | output | 1 | Transaction in progress |
| req_reject | output | 1 | Pulse: illegal differential pairing |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Data toward the converter |
| sdo_oe | output | 1 | Output enable for `sdo` |
| sdi | input | 1 | Data from the converter (or the shared line) |
| sars | input | 1 | Converter busy status |
| res_valid | output | 1 | Result strobe |
| res_data | output | DATA_W | Converted word |
| res_mismatch | output | 1 | The two copies of the word disagree |
| res_timeout | output | 1 | The status sequence was not completed |

## Verification
The bench builds the block with 8 channels, DATA_W=8, a 4-bit divider, TO_CYC=4 and the shared line enabled. This size makes every channel, every single-ended and differential word, and every one of the 64 pairings reachable. A model of the converter shares one wire with the controller, so any overlap between the two drivers is caught at once. Divider ratios 0 and 2 exercise the serial-clock timing. Chosen edge data words, a corrupted least-significant-first copy and a status line held low cover the mismatch and timeout paths.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_WAIT, S_MSB, S_LSB, S_DONE, S_GAP
  } sc_state_t;
endpackage

// File: rtl/sc_clkdiv.sv
module sc_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div_half,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = en && (cnt == div_half);

  always_ff @(posedge clk) begin
    if (rst || !en || tick) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sc_muxword.sv
module sc_muxword #(
  parameter int ADDR_W = 3,
  localparam int MUX_W = ADDR_W + 1
) (
  input  logic [ADDR_W-1:0] pos,
  input  logic [ADDR_W-1:0] neg,
  input  logic              diff,
  output logic [MUX_W-1:0]  word,
  output logic              legal
);
  generate
    if (ADDR_W == 1) begin : g_pair
      assign word  = {~diff, pos[0]};
      assign legal = !diff || (pos[0] != neg[0]);
    end else begin : g_multi
      assign word  = {~diff, pos[0], pos[ADDR_W-1:1]};
      assign legal = !diff ||
                     ((pos[0] != neg[0]) && (pos[ADDR_W-1:1] == neg[ADDR_W-1:1]));
    end
  endgenerate
endmodule

// File: rtl/sc_host.sv
module sc_host #(
  parameter int N_CH   = 8,
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int TO_CYC = 16,
  parameter bit SHARED = 1'b1,
  localparam int ADDR_W  = $clog2(N_CH),
  localparam int MUX_W   = ADDR_W + 1,
  localparam int FRAME_W = MUX_W + 1,
  localparam int CNT_W   = $clog2(FRAME_W + DATA_W + 1),
  localparam int TO_W    = $clog2(TO_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  div_half,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_pos,
  input  logic [ADDR_W-1:0] req_neg,
  input  logic              req_diff,
  output logic              busy,
  output logic              req_reject,
  output logic              cs_n,
  output logic              sclk,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              sdi,
  input  logic              sars,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              res_mismatch,
  output logic              res_timeout
);
  import sc_pkg::*;

  sc_state_t          state;
  logic               tick;
  logic [MUX_W-1:0]   word;
  logic               legal;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   bcnt;
  logic [TO_W-1:0]    tocnt;
  logic [DATA_W-1:0]  msb_sr;
  logic [DATA_W-2:0]  lsb_sr;
  logic               fallen;
  logic               tout;

  assign busy = (state != S_IDLE);

  sc_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .en(busy), .div_half(div_half), .tick(tick)
  );

  sc_muxword #(.ADDR_W(ADDR_W)) u_mux (
    .pos(req_pos), .neg(req_neg), .diff(req_diff), .word(word), .legal(legal)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; cs_n <= 1'b1; sclk <= 1'b0; sdo <= 1'b0; sdo_oe <= 1'b0;
      frame <= '0; bcnt <= '0; tocnt <= '0; msb_sr <= '0; lsb_sr <= '0;
      fallen <= 1'b0; tout <= 1'b0; req_reject <= 1'b0;
      res_valid <= 1'b0; res_data <= '0; res_mismatch <= 1'b0; res_timeout <= 1'b0;
    end else begin
      res_valid  <= 1'b0;
      req_reject <= 1'b0;
      case (state)
        S_IDLE: if (req) begin
          if (!legal) req_reject <= 1'b1;
          else begin
            frame <= {1'b1, word}; sdo <= 1'b1; sdo_oe <= 1'b1; cs_n <= 1'b0;
            bcnt <= '0; tocnt <= '0; fallen <= 1'b0; tout <= 1'b0;
            state <= S_ADDR;
          end
        end
        S_ADDR: if (tick) begin
          if (!sclk) begin
            sclk <= 1'b1;
            bcnt <= bcnt + 1'b1;
          end else begin
            sclk <= 1'b0;
            if (bcnt == CNT_W'(FRAME_W)) begin
              sdo    <= 1'b0;
              sdo_oe <= !SHARED;
              state  <= S_WAIT;
            end else begin
              frame <= frame << 1;
              sdo   <= frame[FRAME_W-2];
            end
          end
        end
        S_WAIT: if (tick) begin
          if (!sclk) begin
            sclk <= 1'b1;
            if (sars) begin
              bcnt  <= '0;
              state <= S_MSB;
            end else if (tocnt == TO_W'(TO_CYC - 1)) begin
              tout  <= 1'b1;
              state <= S_DONE;
            end else tocnt <= tocnt + 1'b1;
          end else sclk <= 1'b0;
        end
        S_MSB: if (tick) begin
          if (!sclk) begin
            sclk   <= 1'b1;
            msb_sr <= {msb_sr[DATA_W-2:0], sdi};
            bcnt   <= bcnt + 1'b1;
            if (bcnt == CNT_W'(DATA_W - 1)) begin
              bcnt  <= '0;
              state <= S_LSB;
            end
          end else sclk <= 1'b0;
        end
        S_LSB: if (tick) begin
          if (!sclk) begin
            sclk   <= 1'b1;
            lsb_sr <= {sdi, lsb_sr[DATA_W-2:1]};
            if (!sars) fallen <= 1'b1;
            bcnt   <= bcnt + 1'b1;
            if (bcnt == CNT_W'(DATA_W - 2)) state <= S_DONE;
          end else sclk <= 1'b0;
        end
        S_DONE: if (tick) begin
          sclk <= 1'b0; cs_n <= 1'b1; sdo <= 1'b0; sdo_oe <= 1'b0;
          res_valid    <= 1'b1;
          res_data     <= msb_sr;
          res_mismatch <= !tout && (lsb_sr != msb_sr[DATA_W-1:1]);
          res_timeout  <= tout || !fallen;
          state <= S_GAP;
        end
        S_GAP: if (tick) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sc_host_chk.sv
module sc_host_chk (
  input logic clk,
  input logic rst,
  input logic req_reject,
  input logic cs_n,
  input logic sclk,
  input logic sdo,
  input logic sdo_oe,
  input logic res_valid
);
  p_sclk_idle_r1: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);
  p_sdo_setup_r2: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !$stable(sdo)) |-> !sclk);
  p_cs_gap_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |=> cs_n);
  p_reject_idle_r7: assert property (@(posedge clk) disable iff (rst)
    req_reject |-> cs_n);
  p_oe_in_frame_r9: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> !cs_n);
  p_valid_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
  p_valid_cs_r11: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> cs_n);
endmodule

bind sc_host sc_host_chk u_chk (
  .clk(clk), .rst(rst), .req_reject(req_reject), .cs_n(cs_n), .sclk(sclk),
  .sdo(sdo), .sdo_oe(sdo_oe), .res_valid(res_valid)
);

// File: tb/sim_sc_host.sv
module sim_sc_host;
  localparam int MW = 4;
  logic clk = 1'b0, rst = 1'b1;
  logic [3:0] div_half = '0;
  logic req = 1'b0, req_diff = 1'b0;
  logic [2:0] req_pos = '0, req_neg = '0;
  logic busy, req_reject, cs_n, sclk, sdo, sdo_oe, res_valid, res_mismatch, res_timeout;
  logic [7:0] res_data;
  logic m_do = 1'b0, m_sars = 1'b0;
  wire line = sdo_oe ? sdo : m_do;

  sc_host #(.N_CH(8), .DATA_W(8), .DIV_W(4), .TO_CYC(4), .SHARED(1'b1)) u0 (
    .clk(clk), .rst(rst), .div_half(div_half), .req(req), .req_pos(req_pos),
    .req_neg(req_neg), .req_diff(req_diff), .busy(busy), .req_reject(req_reject),
    .cs_n(cs_n), .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe), .sdi(line), .sars(m_sars),
    .res_valid(res_valid), .res_data(res_data), .res_mismatch(res_mismatch),
    .res_timeout(res_timeout)
  );

  always #2 clk = ~clk;

  int errs = 0, nchk = 0, cyc = 0;
  // converter model state
  logic [7:0] dat = '0;
  logic stuck = 1'b0, corrupt = 1'b0;
  logic got = 1'b0, adone = 1'b0, p_sclk = 1'b0;
  logic [MW-1:0] mux = '0;
  int nb = 0, k = 0, collide = 0;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++; nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
    end
    if (cs_n) begin
      got = 0; adone = 0; nb = 0; mux = '0; k = 0; m_do = 0; m_sars = 0;
    end else begin
      if (sclk && !p_sclk && !adone) begin
        if (!got) got = line;
        else begin
          mux = {mux[MW-2:0], line}; nb++;
          if (nb == MW) adone = 1;
        end
      end
      if (!sclk && p_sclk && adone) begin
        k++;
        if (stuck) begin m_sars = 0; m_do = 0; end
        else if (k == 1) begin m_sars = 1; m_do = 0; end
        else if (k <= 9) m_do = dat[9-k];
        else if (k <= 16) begin
          m_sars = 0;
          m_do = dat[k-9] ^ (corrupt && k == 13);
        end else m_do = 0;
      end
      if (adone && k >= 1 && sdo_oe) collide++;
    end
    p_sclk = sclk;
  end

  task automatic run(input int pos, input int neg, input bit diff, input int d,
                     input int dv, input bit st, input bit cr);
    logic [MW-1:0] emux;
    int n, w;
    @(negedge clk);
    div_half = 4'(dv); dat = 8'(d); stuck = st; corrupt = cr; collide = 0;
    req_pos = 3'(pos); req_neg = 3'(neg); req_diff = diff; req = 1;
    @(negedge clk); req = 0;
    check(!cs_n, "R1 cs low after accept", cs_n, 0);
    n = 0;
    while (!sclk && n < 100) begin @(negedge clk); n++; end
    check(n == dv + 1, "R8 first sclk rise", n, dv + 1);
    w = 0;
    while (!res_valid && w < 5000) begin
      check(cs_n == 0, "R1 cs held low", cs_n, 0);
      @(negedge clk); w++;
    end
    emux = {~diff, 1'(pos), 1'(pos >> 2), 1'(pos >> 1)};
    check(got, "R2 start bit seen", got, 1);
    check(mux == emux, "R3 mux word", mux, emux);
    check(cs_n, "R11 cs high at valid", cs_n, 1);
    check(collide == 0, "R9 line released", collide, 0);
    if (st) check(res_timeout, "R10 timeout", res_timeout, 1);
    else begin
      check(!res_timeout, "R10 no timeout", res_timeout, 0);
      check(res_data == 8'(d), "R4 data", res_data, d);
      check(res_mismatch == cr, "R5 mismatch", res_mismatch, cr);
    end
    @(negedge clk);
    check(!res_valid, "R11 single pulse", res_valid, 0);
    check(cs_n, "R6 cs gap", cs_n, 1);
    while (busy) @(negedge clk);
  endtask

  task automatic reject(input int pos, input int neg);
    @(negedge clk);
    req_pos = 3'(pos); req_neg = 3'(neg); req_diff = 1; req = 1;
    @(negedge clk); req = 0;
    check(req_reject && cs_n, "R7 reject", {req_reject, cs_n}, 3);
    @(negedge clk);
    check(!busy && cs_n && !req_reject, "R7 no start", {busy, cs_n}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(cs_n && !sclk && !sdo_oe && !busy && !res_valid, "R1 reset state",
          {cs_n, sclk, sdo_oe, busy, res_valid}, 16);
    for (int dv = 0; dv <= 2; dv += 2) begin
      for (int c = 0; c < 8; c++) run(c, 0, 0, (c * 37 + dv * 91 + 5) & 255, dv, 0, 0);
      for (int c = 0; c < 8; c++) run(c, c ^ 1, 1, (c * 53 + dv * 29 + 17) & 255, dv, 0, 0);
    end
    run(0, 0, 0, 8'h00, 1, 0, 0);
    run(0, 0, 0, 8'hFF, 1, 0, 0);
    run(1, 0, 0, 8'h80, 1, 0, 0);
    run(2, 0, 0, 8'h01, 1, 0, 0);
    run(3, 2, 1, 8'hA5, 0, 0, 1);  // R5 corrupted LSB-first copy
    run(5, 0, 0, 8'h3C, 1, 0, 1);
    run(6, 0, 0, 8'h00, 1, 1, 0);  // R10 status never rises
    run(7, 6, 1, 8'h5A, 0, 1, 0);
    for (int p = 0; p < 8; p++)
      for (int q = 0; q < 8; q++)
        if (!((p >> 1) == (q >> 1) && p != q)) reject(p, q);
    run(4, 5, 1, 8'hC3, 0, 0, 0);  // R6 fresh transaction after rejects
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule